// File: doc/BRIEF.md
# Serial Flash Command Sequencer

This block is a register-driven controller that runs a single serial-flash command each time software writes its command register. A command is built from up to four phases, always in the same order: one opcode byte, up to three address bytes, up to fifteen dummy bytes, and up to four data bytes. Data bytes are either sent from the data register or captured into it. The flash side is a one-lane SPI master in mode 3, with a small set of active-low chip-select lines.

Chip select can be held asserted after a command ends. The next command then continues the same flash transaction, and its opcode phase is skipped because chip select is already active. Software can therefore chain short commands of at most four data bytes into a flash transfer of any length. A continuation command with no address, dummy or data bytes does nothing except release chip select.

The controller has one state machine, which steps through the states PH_IDLE, PH_OPCODE, PH_ADDR, PH_DUMMY, PH_DATA and PH_FINISH. Its transitions are:
- PH_IDLE to PH_OPCODE on an accepted command write when chip select is not held.
- PH_IDLE to the first non-empty phase among PH_ADDR, PH_DUMMY and PH_DATA (or to PH_FINISH if all are empty) on an accepted command write when chip select is held.
- From each byte phase, after its last byte, to the next non-empty phase, or to PH_FINISH.
- PH_FINISH to PH_IDLE after one cycle.

A byte shifter below the state machine has two states, EN_IDLE and EN_SHIFT. It moves from EN_IDLE to EN_SHIFT on a start pulse, and from EN_SHIFT back to EN_IDLE after the last tick of bit 7.

Top module: `spi_cmd_sequencer`

The host register map uses word indices on `bus_addr_i`:

| Index | Register |
|---|---|
| 0 | command |
| 1 | address |
| 2 | data |
| 3 | status |
| 4 | timing |

## Requirements
- R1: After reset: status reads 0; data reads 0; timing reads 0x2507 (fall position 2, rise position 5, period 7); every `cs_n_o` line is high; `sck_o` and `mosi_o` are high.
- R2: Command word fields:
  - opcode: bits 7:0
  - write direction: bit 8
  - data length: bits 11:9
  - keep-select: bit 15
  - dummy length: bits 19:16
  - address length: bits 22:20
  - chip-select number: bits 26:24

  A new transaction sends its bytes in this order: opcode, address, dummy, data. A phase of length zero is skipped. Each byte goes out most significant bit first.
- R3: The address bytes come from the low 24 bits of the address register, most significant byte first. With length 3 the order is bits 23:16, 15:8, 7:0; with length 2 it is 15:8, 7:0; with length 1 it is 7:0. An address length above 3 acts as 3.
- R4: Write data is taken from the data register little-endian: bits 7:0 go out first and bits 31:24 go out fourth. A data length above 4 acts as 4. After a write command the data register still holds what software wrote.
- R5: A read command samples `miso_o` on the rising SCK edge, MSB first. Byte k lands in bits 8k+7:8k of the data register, and the unused upper bytes read 0. `mosi_o` stays high while read data is clocked in.
- R6: Every dummy byte goes out as 0x00. Bytes received during the opcode, address and dummy phases never reach the data register.
- R7: With keep-select set, chip select stays low after the command ends. The next command skips its opcode phase and continues the same transaction. With keep-select clear, chip select is released when the command ends.
- R8: A continuation command whose address, dummy and data lengths are all zero sends no bytes and only releases chip select.
- R9: Status bit 22 (pending) is set from the cycle after an accepted command write until the command ends. For a read, the new data register value becomes visible in the same cycle that pending clears.
- R10: Writing the command register while pending is set makes status bit 29 (error) go to 1, and that command is ignored. Writing status with bit 29 set clears the error flag. Writing status with bit 29 clear leaves it unchanged.
- R11: Timing register fields are period in bits 3:0, rise position in bits 11:8 and fall position in bits 15:12, with fall < rise <= period. Each bit cell lasts period+1 clocks, and SCK is low only for ticks from fall up to rise-1. SCK idles high. A one-byte command keeps pending high for 8*(period+1)+3 cycles.
- R12: Only the chip-select line chosen by the number latched at the start of a transaction goes low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Controller clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| bus_we_i | input | 1 | Register write strobe |
| bus_addr_i | input | RA_W | Register word index |
| bus_wdata_i | input | 32 | Register write data |
| bus_rdata_o | output | 32 | Register read data (combinational on index) |
| sck_o | output | 1 | Serial clock, idles high |
| mosi_o | output | 1 | Serial data to flash |
| miso_o | input | 1 | Serial data from flash |
| cs_n_o | output | CS_COUNT | Active-low chip selects |

## Verification
The bench aims at these corner cases:
- **Continuation chains.** It runs write and read commands that extend a held transaction. A design that resent the opcode would put an extra byte on the wire, and a design that reset its byte position would return the wrong read bytes.
- **Empty commands and out-of-range lengths.** It tries zero-length release commands and length fields above their maxima. A design that got these wrong would emit stray clocks or index past the address or data word.
- **Timing of the data update.** It checks that read data is not visible before pending clears. It also writes a command into a busy controller, which must set the error flag and leave the wire untouched.
- **Two timing settings.** It checks the pending width and the SCK low time under both, which exposes an off-by-one in the bit-cell counter.

// File: rtl/flashseq_pkg.sv
package flashseq_pkg;

    typedef enum logic [2:0] {
        PH_IDLE   = 3'd0,
        PH_OPCODE = 3'd1,
        PH_ADDR   = 3'd2,
        PH_DUMMY  = 3'd3,
        PH_DATA   = 3'd4,
        PH_FINISH = 3'd5
    } phase_e;

    typedef struct packed {
        logic [2:0] cs_num;
        logic [2:0] addr_len;
        logic [3:0] dummy_len;
        logic       keep;
        logic [2:0] data_len;
        logic       dir_wr;
        logic [7:0] opcode;
    } cmd_t;

    localparam int unsigned PEND_BIT   = 22;
    localparam int unsigned ERR_BIT    = 29;
    localparam logic [2:0]  MAX_ALEN   = 3'd3;
    localparam logic [2:0]  MAX_DLEN   = 3'd4;

    // Field positions of the command word; lengths beyond their maxima are clamped.
    function automatic cmd_t unpack_cmd(input logic [31:0] w);
        cmd_t c;
        c.opcode    = w[7:0];
        c.dir_wr    = w[8];
        c.data_len  = (w[11:9] > MAX_DLEN) ? MAX_DLEN : w[11:9];
        c.keep      = w[15];
        c.dummy_len = w[19:16];
        c.addr_len  = (w[22:20] > MAX_ALEN) ? MAX_ALEN : w[22:20];
        c.cs_num    = w[26:24];
        return c;
    endfunction

endpackage

// File: rtl/spi_byte_shifter.sv
module spi_byte_shifter #(
    parameter int TW = 4
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          start_i,
    input  logic [7:0]    tx_i,
    input  logic [TW-1:0] per_i,
    input  logic [TW-1:0] rise_i,
    input  logic [TW-1:0] fall_i,
    input  logic          miso_i,
    output logic          done_o,
    output logic [7:0]    rx_o,
    output logic          sck_o,
    output logic          mosi_o
);
    typedef enum logic {EN_IDLE, EN_SHIFT} eng_e;

    eng_e          st_q, st_d;
    logic [TW-1:0] tick_q;
    logic [2:0]    bit_q;
    logic [7:0]    tx_q;
    logic [7:0]    rx_q;
    logic          last_tick;
    logic          rise_hit;
    logic [7:0]    rx_next;

    assign last_tick = (tick_q == per_i);
    assign rise_hit  = (tick_q == rise_i);
    assign rx_next   = rise_hit ? {rx_q[6:0], miso_i} : rx_q;

    // state register
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= EN_IDLE;
        else         st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            EN_IDLE:  if (start_i) st_d = EN_SHIFT;
            EN_SHIFT: if (last_tick && bit_q == 3'd7) st_d = EN_IDLE;
            default:  st_d = EN_IDLE;
        endcase
    end

    // bit-cell counters and shift registers
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            tick_q <= '0;
            bit_q  <= '0;
            tx_q   <= 8'hFF;
            rx_q   <= '0;
            rx_o   <= '0;
            done_o <= 1'b0;
        end else begin
            done_o <= 1'b0;
            unique case (st_q)
                EN_IDLE: begin
                    if (start_i) begin
                        tx_q   <= tx_i;
                        tick_q <= '0;
                        bit_q  <= '0;
                        rx_q   <= '0;
                    end
                end
                EN_SHIFT: begin
                    rx_q <= rx_next;
                    if (last_tick) begin
                        tick_q <= '0;
                        bit_q  <= bit_q + 3'd1;
                        tx_q   <= {tx_q[6:0], 1'b1};
                        if (bit_q == 3'd7) begin
                            done_o <= 1'b1;
                            rx_o   <= rx_next;
                        end
                    end else begin
                        tick_q <= tick_q + 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    // serial outputs: mode 3, clock low only between fall and rise positions
    always_comb begin
        sck_o  = 1'b1;
        mosi_o = 1'b1;
        if (st_q == EN_SHIFT) begin
            mosi_o = tx_q[7];
            if (tick_q >= fall_i && tick_q < rise_i) sck_o = 1'b0;
        end
    end

endmodule

// File: rtl/seq_phase_ctrl.sv
module seq_phase_ctrl
    import flashseq_pkg::*;
(
    input  logic        clk_i,
    input  logic        rst_ni,
    input  logic        go_i,
    input  cmd_t        cmd_i,
    input  logic [31:0] addr_i,
    input  logic [31:0] wdata_i,
    input  logic        byte_done_i,
    input  logic [7:0]  rx_byte_i,
    output logic        byte_start_o,
    output logic [7:0]  tx_byte_o,
    output logic        pending_o,
    output logic        cs_active_o,
    output logic [2:0]  cs_sel_o,
    output logic        rd_load_o,
    output logic [31:0] rd_word_o
);
    phase_e      phase_q, phase_d;
    cmd_t        cmd_q;
    logic [31:0] addr_q;
    logic [31:0] wdata_q;
    logic [31:0] rd_q;
    logic [3:0]  cnt_q;
    logic        inflight_q;
    logic        cs_active_q;
    logic [2:0]  cs_sel_q;
    logic [3:0]  phase_len;
    logic        last_byte;
    logic        byte_phase;
    logic [2:0]  a_sel;

    // first phase at or after 'from' that carries bytes
    function automatic phase_e first_from(input phase_e from, input cmd_t c);
        if (from <= PH_ADDR  && c.addr_len  != 3'd0) return PH_ADDR;
        if (from <= PH_DUMMY && c.dummy_len != 4'd0) return PH_DUMMY;
        if (from <= PH_DATA  && c.data_len  != 3'd0) return PH_DATA;
        return PH_FINISH;
    endfunction

    always_comb begin
        unique case (phase_q)
            PH_OPCODE: phase_len = 4'd1;
            PH_ADDR:   phase_len = {1'b0, cmd_q.addr_len};
            PH_DUMMY:  phase_len = cmd_q.dummy_len;
            PH_DATA:   phase_len = {1'b0, cmd_q.data_len};
            default:   phase_len = 4'd1;
        endcase
    end

    assign last_byte  = (cnt_q == phase_len - 4'd1);
    assign byte_phase = (phase_q == PH_OPCODE) || (phase_q == PH_ADDR) ||
                        (phase_q == PH_DUMMY)  || (phase_q == PH_DATA);

    // state register
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) phase_q <= PH_IDLE;
        else         phase_q <= phase_d;
    end

    // next-state logic
    always_comb begin
        phase_d = phase_q;
        unique case (phase_q)
            PH_IDLE: begin
                if (go_i) phase_d = cs_active_q ? first_from(PH_ADDR, cmd_i) : PH_OPCODE;
            end
            PH_OPCODE, PH_ADDR, PH_DUMMY, PH_DATA: begin
                if (byte_done_i && last_byte) phase_d = first_from(phase_e'(phase_q + 3'd1), cmd_q);
            end
            PH_FINISH: phase_d = PH_IDLE;
            default:   phase_d = PH_IDLE;
        endcase
    end

    // datapath registers
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cmd_q       <= '0;
            addr_q      <= '0;
            wdata_q     <= '0;
            rd_q        <= '0;
            cnt_q       <= '0;
            inflight_q  <= 1'b0;
            cs_active_q <= 1'b0;
            cs_sel_q    <= '0;
        end else begin
            unique case (phase_q)
                PH_IDLE: begin
                    if (go_i) begin
                        cmd_q      <= cmd_i;
                        addr_q     <= addr_i;
                        wdata_q    <= wdata_i;
                        rd_q       <= '0;
                        cnt_q      <= '0;
                        inflight_q <= 1'b0;
                        if (!cs_active_q) begin
                            cs_active_q <= 1'b1;
                            cs_sel_q    <= cmd_i.cs_num;
                        end
                    end
                end
                PH_OPCODE, PH_ADDR, PH_DUMMY, PH_DATA: begin
                    if (!inflight_q) begin
                        inflight_q <= 1'b1;
                    end else if (byte_done_i) begin
                        inflight_q <= 1'b0;
                        if (phase_q == PH_DATA && !cmd_q.dir_wr)
                            rd_q[{cnt_q[1:0], 3'b000} +: 8] <= rx_byte_i;
                        cnt_q <= last_byte ? 4'd0 : cnt_q + 4'd1;
                    end
                end
                PH_FINISH: cs_active_q <= cmd_q.keep;
                default: ;
            endcase
        end
    end

    // outputs
    assign a_sel = cmd_q.addr_len - 3'd1 - cnt_q[2:0];

    always_comb begin
        byte_start_o = byte_phase && !inflight_q;
        tx_byte_o    = 8'h00;
        unique case (phase_q)
            PH_OPCODE: tx_byte_o = cmd_q.opcode;
            PH_ADDR:   tx_byte_o = addr_q[{a_sel[1:0], 3'b000} +: 8];
            PH_DUMMY:  tx_byte_o = 8'h00;
            PH_DATA:   tx_byte_o = cmd_q.dir_wr ? wdata_q[{cnt_q[1:0], 3'b000} +: 8] : 8'hFF;
            default:   tx_byte_o = 8'h00;
        endcase
        pending_o   = (phase_q != PH_IDLE);
        cs_active_o = cs_active_q;
        cs_sel_o    = cs_sel_q;
        rd_load_o   = (phase_q == PH_FINISH) && !cmd_q.dir_wr && (cmd_q.data_len != 3'd0);
        rd_word_o   = rd_q;
    end

endmodule

// File: rtl/spi_cmd_sequencer.sv
module spi_cmd_sequencer
    import flashseq_pkg::*;
#(
    parameter int         CS_COUNT = 4,
    parameter int         RA_W     = 3,
    parameter int         TW       = 4,
    parameter logic [3:0] DEF_PER  = 4'd7,
    parameter logic [3:0] DEF_RISE = 4'd5,
    parameter logic [3:0] DEF_FALL = 4'd2
) (
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic                bus_we_i,
    input  logic [RA_W-1:0]     bus_addr_i,
    input  logic [31:0]         bus_wdata_i,
    output logic [31:0]         bus_rdata_o,
    output logic                sck_o,
    output logic                mosi_o,
    input  logic                miso_o,
    output logic [CS_COUNT-1:0] cs_n_o
);
    localparam logic [RA_W-1:0] REG_CMD  = RA_W'(0);
    localparam logic [RA_W-1:0] REG_ADDR = RA_W'(1);
    localparam logic [RA_W-1:0] REG_DATA = RA_W'(2);
    localparam logic [RA_W-1:0] REG_STAT = RA_W'(3);
    localparam logic [RA_W-1:0] REG_TIME = RA_W'(4);

    logic [31:0]   cmd_word_q;
    logic [31:0]   addr_q;
    logic [31:0]   data_q;
    logic          err_q;
    logic [TW-1:0] per_q, rise_q, fall_q;

    logic          cmd_wr;
    logic          go_w;
    logic          pending_w;
    logic          cs_active_w;
    logic [2:0]    cs_sel_w;
    logic          rd_load_w;
    logic [31:0]   rd_word_w;
    logic          byte_start_w;
    logic [7:0]    tx_byte_w;
    logic          byte_done_w;
    logic [7:0]    rx_byte_w;

    assign cmd_wr = bus_we_i && (bus_addr_i == REG_CMD);
    assign go_w   = cmd_wr && !pending_w;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cmd_word_q <= '0;
            addr_q     <= '0;
            data_q     <= '0;
            err_q      <= 1'b0;
            per_q      <= TW'(DEF_PER);
            rise_q     <= TW'(DEF_RISE);
            fall_q     <= TW'(DEF_FALL);
        end else begin
            if (go_w) cmd_word_q <= bus_wdata_i;
            if (cmd_wr && pending_w) err_q <= 1'b1;
            if (bus_we_i) begin
                unique case (bus_addr_i)
                    REG_ADDR: addr_q <= bus_wdata_i;
                    REG_DATA: data_q <= bus_wdata_i;
                    REG_STAT: if (bus_wdata_i[ERR_BIT]) err_q <= 1'b0;
                    REG_TIME: begin
                        per_q  <= bus_wdata_i[TW-1:0];
                        rise_q <= bus_wdata_i[8 +: TW];
                        fall_q <= bus_wdata_i[12 +: TW];
                    end
                    default: ;
                endcase
            end
            if (rd_load_w) data_q <= rd_word_w;
        end
    end

    always_comb begin
        bus_rdata_o = '0;
        unique case (bus_addr_i)
            REG_CMD:  bus_rdata_o = cmd_word_q;
            REG_ADDR: bus_rdata_o = addr_q;
            REG_DATA: bus_rdata_o = data_q;
            REG_STAT: begin
                bus_rdata_o[PEND_BIT] = pending_w;
                bus_rdata_o[ERR_BIT]  = err_q;
            end
            REG_TIME: begin
                bus_rdata_o[TW-1:0]  = per_q;
                bus_rdata_o[8 +: TW] = rise_q;
                bus_rdata_o[12 +: TW] = fall_q;
            end
            default: bus_rdata_o = '0;
        endcase
    end

    seq_phase_ctrl u_ctrl (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .go_i         (go_w),
        .cmd_i        (unpack_cmd(bus_wdata_i)),
        .addr_i       (addr_q),
        .wdata_i      (data_q),
        .byte_done_i  (byte_done_w),
        .rx_byte_i    (rx_byte_w),
        .byte_start_o (byte_start_w),
        .tx_byte_o    (tx_byte_w),
        .pending_o    (pending_w),
        .cs_active_o  (cs_active_w),
        .cs_sel_o     (cs_sel_w),
        .rd_load_o    (rd_load_w),
        .rd_word_o    (rd_word_w)
    );

    spi_byte_shifter #(.TW(TW)) u_shift (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .start_i (byte_start_w),
        .tx_i    (tx_byte_w),
        .per_i   (per_q),
        .rise_i  (rise_q),
        .fall_i  (fall_q),
        .miso_i  (miso_o),
        .done_o  (byte_done_w),
        .rx_o    (rx_byte_w),
        .sck_o   (sck_o),
        .mosi_o  (mosi_o)
    );

    for (genvar g = 0; g < CS_COUNT; g++) begin : g_cs
        assign cs_n_o[g] = !(cs_active_w && (cs_sel_w == 3'(g)));
    end

endmodule

// File: rtl/seq_checker.sv
module seq_checker #(
    parameter int CS_COUNT = 4,
    parameter int RA_W     = 3
) (
    input logic                clk_i,
    input logic                rst_ni,
    input logic                bus_we_i,
    input logic [RA_W-1:0]     bus_addr_i,
    input logic                sck_o,
    input logic [CS_COUNT-1:0] cs_n_o,
    input logic                pending_w,
    input logic                err_q
);
    logic cmd_wr;
    assign cmd_wr = bus_we_i && (bus_addr_i == RA_W'(0));

    // R11
    sck_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !pending_w |-> sck_o);

    // R12
    cs_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $onehot0(~cs_n_o));

    // R10
    err_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(err_q) |-> $past(cmd_wr && pending_w));

    // R9
    pend_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(pending_w) |-> $past(cmd_wr));

    // R7
    cs_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!pending_w && !cmd_wr) |=> $stable(cs_n_o));

endmodule

bind spi_cmd_sequencer seq_checker #(.CS_COUNT(CS_COUNT), .RA_W(RA_W)) u_chk (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .bus_we_i   (bus_we_i),
    .bus_addr_i (bus_addr_i),
    .sck_o      (sck_o),
    .cs_n_o     (cs_n_o),
    .pending_w  (pending_w),
    .err_q      (err_q)
);

// File: tb/sim_spi_cmd_sequencer.sv
module sim_spi_cmd_sequencer;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        we = 1'b0;
    logic [2:0]  addr = '0;
    logic [31:0] wd = '0;
    logic [31:0] rd;
    logic        sck, mosi;
    logic        miso = 1'b1;
    logic [3:0]  cs_n;

    int tests = 0;
    int fails = 0;

    always #4 clk = ~clk;

    spi_cmd_sequencer u0 (
        .clk_i(clk), .rst_ni(rst_n), .bus_we_i(we), .bus_addr_i(addr),
        .bus_wdata_i(wd), .bus_rdata_o(rd), .sck_o(sck), .mosi_o(mosi),
        .miso_o(miso), .cs_n_o(cs_n)
    );

    // ---------------- behavioural flash responder ----------------
    function automatic logic [7:0] resp(input int n);
        return 8'((n * 29 + 60) & 255);
    endfunction

    logic [7:0] wire_buf [0:63];
    int         wire_n = 0;
    int         r_pos = 0;
    int         r_bit = 0;
    logic [7:0] r_sh = '0;
    wire        none_sel = &cs_n;

    always @(negedge none_sel) begin
        r_pos = 0; r_bit = 0; miso = resp(0)[7];
    end
    always @(posedge sck) if (!none_sel) begin
        r_sh = {r_sh[6:0], mosi};
        r_bit++;
        if (r_bit == 8) begin
            if (wire_n < 64) wire_buf[wire_n] = r_sh;
            wire_n++; r_pos++; r_bit = 0;
        end
    end
    always @(negedge sck) if (!none_sel) miso = resp(r_pos)[7 - r_bit];

    // ---------------- helpers ----------------
    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk); we = 1'b1; addr = a; wd = d;
        @(negedge clk); we = 1'b0;
    endtask

    task automatic bus_read(input logic [2:0] a, output logic [31:0] d);
        addr = a; #1; d = rd;
    endtask

    function automatic logic [31:0] mk(input logic [7:0] opc, input logic wr, input logic [2:0] dl,
                                       input logic keep, input logic [3:0] dum, input logic [2:0] al,
                                       input logic [2:0] cs);
        return {5'd0, cs, 1'b0, al, dum, keep, 3'd0, dl, wr, opc};
    endfunction

    // {command, address, data preload}
    localparam logic [87:0] VEC [0:13] = '{
        {mk(8'h9F,0,3,0,0,0,0), 24'h000000, 32'h5A5A5A5A},
        {mk(8'h03,0,4,0,0,3,0), 24'h123456, 32'h5A5A5A5A},
        {mk(8'h0B,0,2,0,1,3,1), 24'hABCDEF, 32'h5A5A5A5A},
        {mk(8'h02,1,4,1,0,3,2), 24'h001000, 32'hDDCCBBAA},
        {mk(8'h02,1,2,1,0,0,2), 24'h000000, 32'h00006655},
        {mk(8'h03,0,1,0,0,0,2), 24'h000000, 32'h5A5A5A5A},
        {mk(8'h06,0,0,0,0,0,0), 24'h000000, 32'h00000000},
        {mk(8'h05,0,0,1,0,0,3), 24'h000000, 32'h00000000},
        {mk(8'h00,0,0,0,0,0,3), 24'h000000, 32'h00000000},
        {mk(8'h20,1,0,0,0,2,0), 24'h00ABCD, 32'h00000000},
        {mk(8'h5A,0,1,0,15,0,1), 24'h000000, 32'h5A5A5A5A},
        {mk(8'h3B,1,6,0,0,7,0), 24'h010203, 32'h44332211},
        {mk(8'h0C,0,4,1,2,1,0), 24'h00007E, 32'h5A5A5A5A},
        {mk(8'h00,0,3,0,0,0,0), 24'h000000, 32'h5A5A5A5A}
    };

    // bench-side model of the transaction
    logic       m_held = 1'b0;
    logic [2:0] m_sel = '0;
    int         m_pos = 0;

    task automatic run_vec(input int vi, input logic [31:0] c, input logic [23:0] a, input logic [31:0] d);
        logic [7:0]  exp_b [0:31];
        int          exp_n = 0;
        logic [31:0] exp_rd = d;
        int          alen, dlen, dum;
        logic [31:0] s, dv;
        logic        early = 1'b0;
        int          guard = 0;
        int          bad = 0;
        alen = (int'(c[22:20]) > 3) ? 3 : int'(c[22:20]);
        dlen = (int'(c[11:9]) > 4) ? 4 : int'(c[11:9]);
        dum  = int'(c[19:16]);
        if (!m_held) begin
            m_pos = 0; m_sel = c[26:24];
            exp_b[exp_n++] = c[7:0]; m_pos++;
        end
        for (int k = alen - 1; k >= 0; k--) begin exp_b[exp_n++] = a[8*k +: 8]; m_pos++; end
        for (int k = 0; k < dum; k++) begin exp_b[exp_n++] = 8'h00; m_pos++; end
        if (!c[8] && dlen > 0) exp_rd = '0;
        for (int k = 0; k < dlen; k++) begin
            if (c[8]) exp_b[exp_n++] = d[8*k +: 8];
            else begin exp_b[exp_n++] = 8'hFF; exp_rd[8*k +: 8] = resp(m_pos); end
            m_pos++;
        end
        m_held = c[15];

        bus_write(3'd1, {8'h00, a});
        bus_write(3'd2, d);
        wire_n = 0;
        bus_write(3'd0, c);
        bus_read(3'd3, s);
        check($sformatf("R9 vec%0d pending after write", vi), {31'd0, s[22]}, 32'd1);
        while (s[22] && guard < 5000) begin
            bus_read(3'd2, dv);
            if (dv !== d) early = 1'b1;
            @(negedge clk); guard++;
            bus_read(3'd3, s);
        end
        bus_read(3'd2, dv);
        check($sformatf("R9 vec%0d data hidden while pending", vi), {31'd0, early}, 32'd0);
        // R4 R5 data register contents
        check($sformatf("R5 vec%0d data register", vi), dv, exp_rd);
        // R2 R3 R6 wire bytes
        check($sformatf("R2 vec%0d byte count", vi), wire_n, exp_n);
        for (int k = 0; k < exp_n && k < wire_n; k++) if (wire_buf[k] !== exp_b[k]) bad++;
        check($sformatf("R3 vec%0d byte mismatches", vi), bad, 0);
        // R7 R8 R12 chip select after command
        check($sformatf("R7 vec%0d chip select", vi), {28'd0, cs_n},
              m_held ? {28'd0, ~(4'd1 << m_sel)} : 32'h0000000F);
    endtask

    task automatic timed_byte(input logic [31:0] tcfg, input int exp_pend, input int exp_low);
        logic [31:0] s;
        int pend = 0, low = 0;
        bus_write(3'd4, tcfg);
        bus_write(3'd0, mk(8'hA5,0,0,0,0,0,0));
        bus_read(3'd3, s);
        while (s[22] && pend < 5000) begin
            pend++; if (!sck) low++;
            @(negedge clk); bus_read(3'd3, s);
        end
        check("R11 pending width", pend, exp_pend);
        check("R11 sck low cycles", low, exp_low);
        check("R11 sck idle high", {31'd0, sck}, 32'd1);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        fails++; tests++;
        $display("FAIL R9 watchdog actual=running expected=finished");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin : main
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        bus_read(3'd3, v); check("R1 status", v, 32'd0);
        bus_read(3'd2, v); check("R1 data", v, 32'd0);
        bus_read(3'd4, v); check("R1 timing", v, 32'h00002507);
        check("R1 cs_n", {28'd0, cs_n}, 32'h0000000F);
        check("R1 sck mosi", {30'd0, sck, mosi}, 32'd3);

        bus_write(3'd4, 32'h00001305);
        for (int i = 0; i < 14; i++) run_vec(i, VEC[i][87:56], VEC[i][55:32], VEC[i][31:0]);

        // R10 write while busy
        begin
            logic [31:0] s;
            int guard = 0;
            wire_n = 0;
            bus_write(3'd0, mk(8'h66,0,0,0,0,0,0));
            bus_write(3'd0, mk(8'h99,0,0,0,0,0,0));
            bus_read(3'd3, s);
            check("R10 error flag set", {31'd0, s[29]}, 32'd1);
            while (s[22] && guard < 5000) begin @(negedge clk); guard++; bus_read(3'd3, s); end
            check("R10 ignored command bytes", wire_n, 1);
            check("R10 first command byte", {24'd0, wire_buf[0]}, 32'h66);
            bus_write(3'd3, 32'd0);
            bus_read(3'd3, s); check("R10 write 0 keeps flag", {31'd0, s[29]}, 32'd1);
            bus_write(3'd3, 32'h20000000);
            bus_read(3'd3, s); check("R10 write 1 clears flag", {31'd0, s[29]}, 32'd0);
        end

        // R11 two timing settings
        timed_byte(32'h00001305, 51, 16);
        timed_byte(32'h00000203, 35, 16);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule